// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block is a memory-mapped parallel I/O unit with two 8-bit ports, A and B, reached over a simple CPU bus. The bus has an address, write data, read data, a write strobe and a read strobe. Each port has an output latch and a direction register. The block drives, for each pin, an output enable, an output value and a pull-down enable. It also raises one interrupt request, formed as a wired-OR of low-level conditions on pins that are configured as inputs.

Port A has per-pin interrupt enables and per-pin pull-down enables. Two bus addresses are shared between the port A data and direction registers and the port A interrupt-enable and pull-down-enable registers. A bank bit in the control register picks which pair is visible. Port B has one pull-down enable and one interrupt enable, both held in the control register, and each covers the whole port. Pin levels pass through a two-stage synchroniser before they are read back or used for the interrupt.

Address map (3-bit address): 0 is the first shared port A slot, 1 is the port B data register, 2 is the second shared port A slot, 3 is the port B direction register, 4 is the control register, and 5 to 7 are unused.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction register, interrupt-enable register, pull-down-enable register and the control register is zero. All output enables, pull-down outputs and the interrupt request are low, and bank 0 is selected.
- R2: With control bit 0 (bank) clear, address 0 is the port A data register and address 2 is the port A direction register.
- R3: With the bank bit set, address 0 is the port A per-pin interrupt-enable register and address 2 is the port A per-pin pull-down-enable register. Writes to these addresses leave the port A latch and direction unchanged.
- R4: A direction bit of 1 makes that pin an output, driving its output enable and the latch value. A direction bit of 0 makes the pin an input. This applies to both ports. Port B data is at address 1 and port B direction is at address 3.
- R5: Reading a data address returns the latch bit for output pins and the synchronised pin level for input pins. A write to a data address always updates the latch.
- R6: The pull-down output of a port A pin is its pull-down-enable bit ANDed with "pin is an input". When control bit 1 is set, every port B input pin has its pull-down on. Pins configured as outputs never have a pull-down.
- R7: The interrupt request is high while any enabled pin that is configured as an input reads low. Port A uses per-pin enables. Port B uses control bit 2 as a single enable for the whole port.
- R8: A change on a pin input reaches reads and the interrupt after exactly two rising clock edges.
- R9: The control register is at address 4: bit 0 is the bank, bit 1 is the port B pull-down, and bit 2 is the port B interrupt enable. Bits 7 to 3 read back as zero.
- R10: Addresses 5 to 7 read as zero, and writes to them change no state.
- R11: Read data is registered. It takes its new value on the clock edge where the read strobe is sampled high, and holds that value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_oe | output | 8 | Port A output enables |
| pa_out | output | 8 | Port A output values |
| pa_pd | output | 8 | Port A pull-down enables |
| pb_in | input | 8 | Port B pin levels |
| pb_oe | output | 8 | Port B output enables |
| pb_out | output | 8 | Port B output values |
| pb_pd | output | 8 | Port B pull-down enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the write and read strobes are never high in the same cycle, and that the address is stable whenever either strobe is high. The bench meets both conditions: every bus access is one strobe at a time, driven on the falling edge and held for a full clock. Pin inputs are likewise driven only on falling edges, so the two-edge synchroniser latency can be counted exactly. Each pin change is followed by at least two edges before any read or interrupt sample is checked.

// File: rtl/gpio_pkg.sv
// Package: gpio_pkg
// Shared constants and types for the banked GPIO controller.
// Assumes a 3-bit register address space and byte-wide registers.
package gpio_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_A_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_B_DAT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_A_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_B_DIR = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTL   = 3'd4;

    localparam int CTL_BANK_BIT = 0;
    localparam int CTL_BPD_BIT  = 1;
    localparam int CTL_BIE_BIT  = 2;

    typedef struct packed {
        logic b_ie;
        logic b_pd;
        logic bank;
    } ctl_t;
endpackage

// File: rtl/gpio_sync2.sv
// Module: gpio_sync2
// Two-stage synchroniser for W asynchronous pin levels.
// Assumes pins are quasi-static relative to the clock; output lags input by two edges.
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [1:0]   warm;

    // Purpose: shift pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_in;
            stage2 <= stage1;
        end
    end

    // Purpose: count cycles since reset so the latency check never looks before reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm <= 2'd0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    assign q_out = stage2;

    // R8: the synchronised value equals the pin level two edges earlier
    p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (q_out == $past(d_in, 2)));
endmodule

// File: rtl/gpio_port.sv
// Module: gpio_port
// One parallel port: an output latch, a direction register, a pin synchroniser,
// pull-down gating and an interrupt term. PER_PIN selects per-pin enables;
// otherwise bit 0 of each enable vector covers the whole port.
// Assumes the write strobes are single-cycle and are decoded upstream.
module gpio_port #(
    parameter int W       = 8,
    parameter bit PER_PIN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wr_data,
    input  logic         we_data,
    input  logic         we_dir,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] ie_cfg,
    input  logic [W-1:0] pd_cfg,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] view,
    output logic [W-1:0] pd_out,
    output logic         irq_term
);
    logic [W-1:0] pin_s;
    logic [W-1:0] ie_eff;
    logic [W-1:0] pd_eff;

    gpio_sync2 #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (pin_s)
    );

    // Purpose: choose per-pin or whole-port enable interpretation.
    generate
        if (PER_PIN) begin : g_per_pin
            assign ie_eff = ie_cfg;
            assign pd_eff = pd_cfg;
        end else begin : g_group
            logic [W-2:0] unused_cfg;
            assign unused_cfg = ie_cfg[W-1:1] ^ pd_cfg[W-1:1];
            assign ie_eff = {W{ie_cfg[0]}};
            assign pd_eff = {W{pd_cfg[0]}};
        end
    endgenerate

    // Purpose: hold the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (we_data)
            latch_q <= wr_data;
    end

    // Purpose: hold the direction register (1 = output).
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (we_dir)
            dir_q <= wr_data;
    end

    // Purpose: form the read view, pull-downs and the interrupt term.
    always_comb begin
        view     = (latch_q & dir_q) | (pin_s & ~dir_q);
        pd_out   = pd_eff & ~dir_q;
        irq_term = |(ie_eff & ~dir_q & ~pin_s);
    end

    // R4: direction only changes on its own write strobe
    p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_dir |=> $stable(dir_q));

    // R5: the latch only changes on a data write
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_data |=> $stable(latch_q));
endmodule

// File: rtl/gpio_regfile.sv
// Module: gpio_regfile
// Bus decode, control register, port A interrupt/pull-down enable registers,
// and the registered read multiplexer with the bank-dependent mapping.
// Assumes wr_en and rd_en are never high together.
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [W-1:0]      a_view,
    input  logic [W-1:0]      a_dir,
    input  logic [W-1:0]      b_view,
    input  logic [W-1:0]      b_dir,
    output logic              we_a_data,
    output logic              we_a_dir,
    output logic              we_b_data,
    output logic              we_b_dir,
    output logic [W-1:0]      a_ie,
    output logic [W-1:0]      a_pd,
    output ctl_t              ctl,
    output logic [W-1:0]      rd_data
);
    localparam int CTL_W = $bits(ctl_t);

    logic         hit_lo;
    logic         hit_hi;
    logic         we_ctl;
    logic         we_a_ie;
    logic         we_a_pd;
    logic [W-1:0] rd_mux;

    // Purpose: decode write strobes, steering the shared slots by bank.
    always_comb begin
        hit_lo    = wr_en && (addr == ADR_A_LO);
        hit_hi    = wr_en && (addr == ADR_A_HI);
        we_a_data = hit_lo && !ctl.bank;
        we_a_dir  = hit_hi && !ctl.bank;
        we_a_ie   = hit_lo &&  ctl.bank;
        we_a_pd   = hit_hi &&  ctl.bank;
        we_b_data = wr_en && (addr == ADR_B_DAT);
        we_b_dir  = wr_en && (addr == ADR_B_DIR);
        we_ctl    = wr_en && (addr == ADR_CTL);
    end

    // Purpose: hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (we_ctl)
            ctl <= wr_data[CTL_W-1:0];
    end

    // Purpose: hold the port A interrupt and pull-down enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ie <= '0;
            a_pd <= '0;
        end else begin
            if (we_a_ie) a_ie <= wr_data;
            if (we_a_pd) a_pd <= wr_data;
        end
    end

    // Purpose: select read data by address and bank.
    always_comb begin
        rd_mux = '0;
        case (addr)
            ADR_A_LO:  rd_mux = ctl.bank ? a_ie : a_view;
            ADR_A_HI:  rd_mux = ctl.bank ? a_pd : a_dir;
            ADR_B_DAT: rd_mux = b_view;
            ADR_B_DIR: rd_mux = b_dir;
            ADR_CTL:   rd_mux = {{(W-CTL_W){1'b0}}, ctl};
            default:   rd_mux = '0;
        endcase
    end

    // Purpose: register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end

    // R11: read data holds while no read is strobed
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R9: unused control bits read back as zero
    p_ctl_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_CTL) |=> (rd_data[W-1:CTL_W] == '0));

    // R10: unused addresses read as zero
    p_unused_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > ADR_CTL) |=> (rd_data == '0));

    // R10: a write to an unused address leaves the enables and control alone
    p_unused_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADR_CTL) |=> ($stable(ctl) && $stable(a_ie) && $stable(a_pd)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: gpio_bank_ctrl
// Top level of the banked GPIO controller: port A with per-pin enables,
// port B with whole-port enables from the control register, and one interrupt.
// Assumes a single bus master that never issues a read and a write in the same cycle.
module gpio_bank_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_oe,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_pd,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_oe,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_pd,
    output logic              irq
);
    logic              we_a_data, we_a_dir, we_b_data, we_b_dir;
    logic [DATA_W-1:0] a_ie, a_pd, a_view, b_view;
    logic [DATA_W-1:0] b_ie_vec, b_pd_vec;
    logic              irq_a, irq_b;
    ctl_t              ctl;

    gpio_regfile #(.W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .a_view    (a_view),
        .a_dir     (pa_oe),
        .b_view    (b_view),
        .b_dir     (pb_oe),
        .we_a_data (we_a_data),
        .we_a_dir  (we_a_dir),
        .we_b_data (we_b_data),
        .we_b_dir  (we_b_dir),
        .a_ie      (a_ie),
        .a_pd      (a_pd),
        .ctl       (ctl),
        .rd_data   (rd_data)
    );

    gpio_port #(.W(DATA_W), .PER_PIN(1'b1)) u_port_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .we_data  (we_a_data),
        .we_dir   (we_a_dir),
        .pin_in   (pa_in),
        .ie_cfg   (a_ie),
        .pd_cfg   (a_pd),
        .dir_q    (pa_oe),
        .latch_q  (pa_out),
        .view     (a_view),
        .pd_out   (pa_pd),
        .irq_term (irq_a)
    );

    // Purpose: widen the port B group enables to the port's pin vector.
    always_comb begin
        b_ie_vec = {{(DATA_W-1){1'b0}}, ctl.b_ie};
        b_pd_vec = {{(DATA_W-1){1'b0}}, ctl.b_pd};
    end

    gpio_port #(.W(DATA_W), .PER_PIN(1'b0)) u_port_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .we_data  (we_b_data),
        .we_dir   (we_b_dir),
        .pin_in   (pb_in),
        .ie_cfg   (b_ie_vec),
        .pd_cfg   (b_pd_vec),
        .dir_q    (pb_oe),
        .latch_q  (pb_out),
        .view     (b_view),
        .pd_out   (pb_pd),
        .irq_term (irq_b)
    );

    // Purpose: merge the wired-OR interrupt terms.
    assign irq = irq_a | irq_b;

    // R1: the first cycle after reset has all pins as inputs and no interrupt
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pa_oe == '0 && pb_oe == '0 && pa_pd == '0 && !irq));

    // R3: bank-1 writes to the shared slots leave the port A latch and direction alone
    p_bank1_isolate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl.bank && (addr == ADR_A_LO || addr == ADR_A_HI))
            |=> ($stable(pa_out) && $stable(pa_oe)));

    // R2: bank-0 writes to the shared slots leave the port A enables alone
    p_bank0_isolate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctl.bank && (addr == ADR_A_LO || addr == ADR_A_HI))
            |=> ($stable(a_ie) && $stable(a_pd)));

    // R7: with no interrupt enabled anywhere the request stays low
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ie == '0 && !ctl.b_ie) |-> !irq);

    // R6: with port B pull-down disabled no port B pull-down is driven
    p_pb_pd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.b_pd |-> (pb_pd == '0));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pa_in = 8'hFF;
    logic [7:0] pa_oe, pa_out, pa_pd;
    logic [7:0] pb_in = 8'hFF;
    logic [7:0] pb_oe, pb_out, pb_pd;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .pa_in(pa_in), .pa_oe(pa_oe), .pa_out(pa_out), .pa_pd(pa_pd),
        .pb_in(pb_in), .pb_oe(pb_oe), .pb_out(pb_out), .pb_pd(pb_pd),
        .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pa_pd", pa_pd, 8'h00);
        check("R1 pb_pd", pb_pd, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        bus_rd(3'd4, v);
        check("R1 ctl", v, 8'h00);
        bus_rd(3'd2, v);
        check("R1 bank0 dir A", v, 8'h00);
    endtask

    task automatic t_bank0();
        logic [7:0] v;
        bus_wr(3'd2, 8'h0F);
        bus_wr(3'd0, 8'hA5);
        check("R4 pa_oe", pa_oe, 8'h0F);
        check("R4 pa_out", pa_out, 8'hA5);
        @(negedge clk); pa_in = 8'h3C;
        settle();
        bus_rd(3'd0, v);
        check("R2 R5 A data view", v, (8'hA5 & 8'h0F) | (8'h3C & 8'hF0));
        bus_rd(3'd2, v);
        check("R2 A dir readback", v, 8'h0F);
    endtask

    task automatic t_bank1();
        logic [7:0] v;
        bus_wr(3'd4, 8'h01);
        bus_wr(3'd0, 8'h81);
        bus_wr(3'd2, 8'hF0);
        check("R3 latch untouched", pa_out, 8'hA5);
        check("R3 dir untouched", pa_oe, 8'h0F);
        check("R6 A pull-down", pa_pd, 8'hF0);
        bus_rd(3'd0, v);
        check("R3 A ie readback", v, 8'h81);
        bus_rd(3'd2, v);
        check("R3 A pd readback", v, 8'hF0);
        bus_wr(3'd2, 8'hFF);
        check("R6 pd masked on outputs", pa_pd, 8'hF0);
        bus_wr(3'd4, 8'h00);
        bus_rd(3'd2, v);
        check("R2 back to bank0 dir", v, 8'h0F);
    endtask

    task automatic t_port_b();
        logic [7:0] v;
        bus_wr(3'd3, 8'hF0);
        bus_wr(3'd1, 8'h5A);
        check("R4 pb_oe", pb_oe, 8'hF0);
        check("R4 pb_out", pb_out, 8'h5A);
        @(negedge clk); pb_in = 8'h0F;
        settle();
        bus_rd(3'd1, v);
        check("R5 B data view", v, 8'h5F);
        bus_wr(3'd1, 8'hC3);
        check("R5 latch updates", pb_out, 8'hC3);
        check("R6 B pd off", pb_pd, 8'h00);
        bus_wr(3'd4, 8'h02);
        check("R6 B pd group", pb_pd, 8'h0F);
        bus_wr(3'd4, 8'hFF);
        bus_rd(3'd4, v);
        check("R9 ctl readback", v, 8'h07);
        bus_wr(3'd4, 8'h00);
    endtask

    task automatic t_irq();
        // Port A: clear direction, enable pin 0 only
        bus_wr(3'd2, 8'h00);
        @(negedge clk); pa_in = 8'hFF; pb_in = 8'hFF;
        bus_wr(3'd4, 8'h01);
        bus_wr(3'd0, 8'h01);
        bus_wr(3'd2, 8'h00);
        bus_wr(3'd4, 8'h00);
        bus_wr(3'd3, 8'h00);
        settle();
        check("R7 idle irq", {7'd0, irq}, 8'h00);
        @(negedge clk); pa_in = 8'hFE;
        @(negedge clk);
        check("R8 one edge, no irq yet", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R8 R7 irq after two edges", {7'd0, irq}, 8'h01);
        @(negedge clk); pa_in = 8'h01;
        settle();
        check("R7 disabled pins ignored", {7'd0, irq}, 8'h00);
        @(negedge clk); pa_in = 8'h00;
        settle();
        bus_wr(3'd2, 8'h01);
        check("R7 output pin masked", {7'd0, irq}, 8'h00);
        bus_wr(3'd2, 8'h00);
        check("R7 input again", {7'd0, irq}, 8'h01);
        @(negedge clk); pa_in = 8'hFF;
        settle();
        // Port B group enable
        @(negedge clk); pb_in = 8'hDF;
        settle();
        check("R7 B low but disabled", {7'd0, irq}, 8'h00);
        bus_wr(3'd4, 8'h04);
        check("R7 B group irq", {7'd0, irq}, 8'h01);
        bus_wr(3'd3, 8'h20);
        check("R7 B output masked", {7'd0, irq}, 8'h00);
        bus_wr(3'd4, 8'h00);
        bus_wr(3'd3, 8'h00);
        @(negedge clk); pb_in = 8'hFF;
        settle();
    endtask

    task automatic t_unused();
        logic [7:0] v;
        bus_wr(3'd6, 8'hFF);
        bus_wr(3'd5, 8'hFF);
        bus_wr(3'd7, 8'hFF);
        check("R10 pa_oe unchanged", pa_oe, 8'h00);
        check("R10 pb_pd unchanged", pb_pd, 8'h00);
        bus_rd(3'd4, v);
        check("R10 ctl unchanged", v, 8'h00);
        for (int a = 5; a < 8; a++) begin
            bus_rd(a[2:0], v);
            check("R10 unused read", v, 8'h00);
        end
    endtask

    task automatic t_rd_hold();
        logic [7:0] v;
        bus_wr(3'd4, 8'h05);
        bus_rd(3'd4, v);
        check("R11 read captured", v, 8'h05);
        bus_wr(3'd4, 8'h00);
        repeat (3) @(negedge clk);
        check("R11 held without strobe", rd_data, 8'h05);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_bank0();
        t_bank1();
        t_port_b();
        t_irq();
        t_unused();
        t_rd_hold();
        finish_run();
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule